// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block produces the row-scan timing of a multiplexed dot-matrix LCD driver. A one-cycle `line_tick` pulse marks each line period. On every pulse a line counter steps to the next common output, wrapping at the number of lines set by the selected duty. A latch strobe tells the display data latch to capture the row that the counter now addresses. The RAM row to fetch is the programmed start row plus the line count, folded into the 65-row store. The latch alone carries any inverse, blanking or all-on treatment, so RAM contents are never touched.

A chip in master mode generates its own frame polarity signal and a frame sync. In normal mode the polarity flips once per frame, so the panel sees an AC drive over two frames. In line-inversion mode it also flips after every group of n lines. The group length is programmed as n-1, and the group count restarts at each frame boundary. A chip in slave mode passes the polarity from its master straight through. It also snaps its line counter back to line 0 whenever the master's sync is seen on a line tick. A clear command returns the start row and the inversion setting to zero without disturbing the scan.

Top module: `lcd_scan_timer`

## Requirements
- R1: After synchronous reset `com_idx`=0, `fr_out`=0, `latch_stb`=0, `ram_row`=0, and the start row, inversion count and inversion enable are all 0.
- R2: `com_idx` steps by one on each clock with `line_tick`=1, holds otherwise, and goes to 0 on the tick after line L-1. L follows `duty_sel`: 0→64, 1→48, 2→32, 3→24, 4→16, and 5, 6, 7→64.
- R3: `latch_stb` is high for exactly the one clock after each `line_tick` clock, which is the first clock showing the new `com_idx`. It is low at all other times.
- R4: `ram_row` = (start row + `com_idx`) mod 65 at all times. It is always below 65, even for start values 65..127.
- R5: In master mode with inversion disabled, `fr_out` toggles only on the tick that wraps `com_idx` to 0.
- R6: In master mode with inversion enabled and count register m, `fr_out` toggles on every tick that completes a group of m+1 lines, and also on every frame wrap. The group count restarts at each frame wrap, and a wrap that coincides with a group end gives a single toggle.
- R7: In master mode `sync_out` is 1 exactly while `com_idx`=0, and `ext_sync` has no effect on the counter.
- R8: In slave mode (`is_master`=0) `fr_out` equals `ext_fr`, `sync_out` is 0, and a tick with `ext_sync`=1 sets `com_idx` to 0.
- R9: `cfg_wr` loads the start row, inversion count and enable. `cmd_clr` (which has priority over `cfg_wr`) sets all three to 0 and leaves `com_idx` and `fr_out` unchanged.
- R10: If `duty_sel` shrinks L to a value at or below the current `com_idx`, the next tick sets `com_idx` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle line clock pulse |
| is_master | input | 1 | 1 = master (own FR/SYNC), 0 = slave |
| ext_fr | input | 1 | Frame polarity from master (slave mode) |
| ext_sync | input | 1 | Frame sync from master (slave mode) |
| duty_sel | input | 3 | Duty selection code |
| cfg_wr | input | 1 | Load configuration fields |
| cfg_start | input | 7 | Start row shown on common 0 |
| cfg_inv_m1 | input | 5 | Inversion group length minus one |
| cfg_inv_en | input | 1 | Enable line inversion |
| cmd_clr | input | 1 | Clear start row and inversion setting |
| com_idx | output | 6 | Current common index |
| ram_row | output | 7 | RAM row to latch |
| fr_out | output | 1 | Frame polarity |
| sync_out | output | 1 | Frame sync (master) |
| latch_stb | output | 1 | Display data latch strobe |

## Verification
The hardest case to reach is a line-inversion group boundary that coincides with a frame wrap, together with the carry of group phase across frames. The stimulus reaches these by sweeping full multi-frame runs in two inversion setups. One uses a group length that does not divide the line count (32 lines, n=5). The other uses one that does (24 lines, n=8). The expected polarity comes from a closed-form toggle count per tick index. A mid-frame clear and a duty shrink below the current line are driven from a known count, so that the unchanged scan and the forced wrap can be seen at the ports.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
    localparam int ROWS   = 65;
    localparam int ROW_W  = 7;
    localparam int CNT_W  = 6;
    localparam int INV_W  = 5;
    localparam int DUTY_W = 3;

    typedef enum logic [DUTY_W-1:0] {
        DUTY_64 = 3'd0,
        DUTY_48 = 3'd1,
        DUTY_32 = 3'd2,
        DUTY_24 = 3'd3,
        DUTY_16 = 3'd4
    } duty_e;

    typedef struct packed {
        logic [ROW_W-1:0] start;
        logic [INV_W-1:0] inv_m1;
        logic             inv_en;
    } scan_cfg_t;

    typedef struct packed {
        logic tick;
        logic wrap;
    } line_evt_t;

    function automatic logic [CNT_W:0] duty_lines(input logic [DUTY_W-1:0] sel);
        logic [CNT_W:0] n;
        case (duty_e'(sel))
            DUTY_48: n = (CNT_W+1)'(48);
            DUTY_32: n = (CNT_W+1)'(32);
            DUTY_24: n = (CNT_W+1)'(24);
            DUTY_16: n = (CNT_W+1)'(16);
            default: n = (CNT_W+1)'(64);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/lcd_line_counter.sv
`timescale 1ns/1ps
module lcd_line_counter
    import lcd_scan_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          resync,
    input  logic [CW:0]   lines,
    output logic [CW-1:0] cnt,
    output line_evt_t     evt,
    output logic          stb
);
    logic at_end;

    always_comb begin
        at_end   = (({1'b0, cnt} + (CW+1)'(1)) >= lines);
        evt.tick = tick;
        evt.wrap = tick && (resync || at_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            stb <= 1'b0;
        end else begin
            stb <= tick;
            if (evt.wrap)
                cnt <= '0;
            else if (tick)
                cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/lcd_fr_gen.sv
`timescale 1ns/1ps
module lcd_fr_gen
    import lcd_scan_pkg::*;
#(
    parameter int IW = INV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  line_evt_t     evt,
    input  logic          inv_en,
    input  logic [IW-1:0] inv_m1,
    output logic          fr
);
    logic [IW-1:0] grp_cnt;
    logic          grp_end;

    always_comb grp_end = inv_en && evt.tick && (grp_cnt >= inv_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_cnt <= '0;
            fr      <= 1'b0;
        end else if (evt.tick) begin
            if (evt.wrap || grp_end || !inv_en)
                grp_cnt <= '0;
            else
                grp_cnt <= grp_cnt + IW'(1);
            if (evt.wrap || grp_end)
                fr <= ~fr;
        end
    end
endmodule

// File: rtl/lcd_row_map.sv
`timescale 1ns/1ps
module lcd_row_map
    import lcd_scan_pkg::*;
#(
    parameter int NROWS = ROWS,
    parameter int RW    = ROW_W,
    parameter int CW    = CNT_W
) (
    input  logic [RW-1:0] start,
    input  logic [CW-1:0] cnt,
    output logic [RW-1:0] row
);
    localparam int MAXSUM = (2**RW - 1) + (2**CW - 1);
    localparam int SUM_W  = $clog2(MAXSUM + 1);
    localparam int SUBS   = MAXSUM / NROWS;

    logic [SUM_W-1:0] stage [SUBS+1];

    assign stage[0] = SUM_W'(start) + SUM_W'(cnt);

    for (genvar g = 0; g < SUBS; g++) begin : g_fold
        assign stage[g+1] = (stage[g] >= SUM_W'(NROWS)) ? stage[g] - SUM_W'(NROWS)
                                                        : stage[g];
    end

    assign row = stage[SUBS][RW-1:0];
endmodule

// File: rtl/lcd_scan_timer.sv
`timescale 1ns/1ps
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int NROWS = ROWS,
    parameter int RW    = ROW_W,
    parameter int CW    = CNT_W,
    parameter int IW    = INV_W,
    parameter int DW    = DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_tick,
    input  logic          is_master,
    input  logic          ext_fr,
    input  logic          ext_sync,
    input  logic [DW-1:0] duty_sel,
    input  logic          cfg_wr,
    input  logic [RW-1:0] cfg_start,
    input  logic [IW-1:0] cfg_inv_m1,
    input  logic          cfg_inv_en,
    input  logic          cmd_clr,
    output logic [CW-1:0] com_idx,
    output logic [RW-1:0] ram_row,
    output logic          fr_out,
    output logic          sync_out,
    output logic          latch_stb
);
    scan_cfg_t      cfg_q;
    line_evt_t      evt;
    logic [CW:0]    lines;
    logic           resync;
    logic           fr_int;

    always_ff @(posedge clk) begin
        if (rst || cmd_clr) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.start  <= cfg_start;
            cfg_q.inv_m1 <= cfg_inv_m1;
            cfg_q.inv_en <= cfg_inv_en;
        end
    end

    always_comb begin
        lines  = duty_lines(duty_sel);
        resync = !is_master && ext_sync;
    end

    lcd_line_counter #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (line_tick),
        .resync (resync),
        .lines  (lines),
        .cnt    (com_idx),
        .evt    (evt),
        .stb    (latch_stb)
    );

    lcd_fr_gen #(.IW(IW)) u_fr (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .inv_en (cfg_q.inv_en),
        .inv_m1 (cfg_q.inv_m1),
        .fr     (fr_int)
    );

    lcd_row_map #(.NROWS(NROWS), .RW(RW), .CW(CW)) u_map (
        .start (cfg_q.start),
        .cnt   (com_idx),
        .row   (ram_row)
    );

    always_comb begin
        fr_out   = is_master ? fr_int : ext_fr;
        sync_out = is_master && (com_idx == '0);
    end
endmodule

// File: rtl/lcd_scan_timer_chk.sv
`timescale 1ns/1ps
module lcd_scan_timer_chk
    import lcd_scan_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             line_tick,
    input logic             is_master,
    input logic             ext_sync,
    input logic [CNT_W-1:0] com_idx,
    input logic [ROW_W-1:0] ram_row,
    input logic             fr_out,
    input logic             sync_out,
    input logic             latch_stb
);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !line_tick |=> $stable(com_idx));

    p_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        line_tick |=> latch_stb);

    p_nostrobe_r3: assert property (@(posedge clk) disable iff (rst)
        !line_tick |=> !latch_stb);

    p_row_range_r4: assert property (@(posedge clk) disable iff (rst)
        ram_row < ROW_W'(ROWS));

    p_fr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (is_master && !line_tick) |=> (!is_master || $stable(fr_out)));

    p_sync_line0_r7: assert property (@(posedge clk) disable iff (rst)
        (is_master && $past(is_master) && $rose(sync_out)) |-> latch_stb);

    p_slave_nosync_r8: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> !sync_out);

    p_slave_align_r8: assert property (@(posedge clk) disable iff (rst)
        (!is_master && line_tick && ext_sync) |=> (com_idx == '0));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_tick (line_tick),
    .is_master (is_master),
    .ext_sync  (ext_sync),
    .com_idx   (com_idx),
    .ram_row   (ram_row),
    .fr_out    (fr_out),
    .sync_out  (sync_out),
    .latch_stb (latch_stb)
);

// File: tb/tb_lcd_scan_timer.sv
`timescale 1ns/1ps
module tb_lcd_scan_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_tick = 1'b0;
    logic       is_master = 1'b1;
    logic       ext_fr = 1'b0;
    logic       ext_sync = 1'b0;
    logic [2:0] duty_sel = 3'd0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_start = '0;
    logic [4:0] cfg_inv_m1 = '0;
    logic       cfg_inv_en = 1'b0;
    logic       cmd_clr = 1'b0;
    logic [5:0] com_idx;
    logic [6:0] ram_row;
    logic       fr_out, sync_out, latch_stb;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcd_scan_timer dut (
        .clk(clk), .rst(rst), .line_tick(line_tick), .is_master(is_master),
        .ext_fr(ext_fr), .ext_sync(ext_sync), .duty_sel(duty_sel),
        .cfg_wr(cfg_wr), .cfg_start(cfg_start), .cfg_inv_m1(cfg_inv_m1),
        .cfg_inv_en(cfg_inv_en), .cmd_clr(cmd_clr), .com_idx(com_idx),
        .ram_row(ram_row), .fr_out(fr_out), .sync_out(sync_out),
        .latch_stb(latch_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
    endtask

    task automatic cfg(input int s, input int m1, input bit en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_start = 7'(s); cfg_inv_m1 = 5'(m1); cfg_inv_en = en;
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    // n = 0: inversion off; otherwise group length n
    task automatic run_master(input int dsel, input int L, input int s, input int n,
                              input int count);
        is_master = 1'b1;
        duty_sel = 3'(dsel);
        do_reset();
        cfg(s, (n > 0) ? n - 1 : 0, n > 0);
        chk("R4 row after cfg", ram_row, s % 65);
        for (int k = 1; k <= count; k++) begin
            int c, tg;
            tick();
            c = k % L;
            if (n > 0) tg = (k / L) * (((L - 1) / n) + 1) + (c / n);
            else       tg = k / L;
            chk("R2 com_idx", com_idx, c);
            chk("R3 strobe high", latch_stb, 1);
            chk("R4 ram_row", ram_row, (s + c) % 65);
            chk((n > 0) ? "R6 fr inversion" : "R5 fr frame", fr_out, tg % 2);
            chk("R7 sync", sync_out, (c == 0) ? 1 : 0);
            @(negedge clk);
            chk("R3 strobe low", latch_stb, 0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int fr_keep;
        do_reset();
        @(negedge clk);
        chk("R1 com_idx", com_idx, 0);
        chk("R1 fr", fr_out, 0);
        chk("R1 strobe", latch_stb, 0);
        chk("R1 ram_row", ram_row, 0);
        chk("R1 sync", sync_out, 1);
        repeat (5) @(negedge clk);
        chk("R2 hold without tick", com_idx, 0);

        // duty sweep, normal polarity, several start rows including >64
        run_master(0, 64, 50, 0, 130);
        run_master(1, 48, 3, 0, 100);
        run_master(2, 32, 64, 0, 70);
        run_master(3, 24, 100, 0, 52);
        run_master(4, 16, 127, 0, 36);
        run_master(5, 64, 0, 0, 66);
        run_master(7, 64, 1, 0, 66);

        // line inversion: non-dividing and dividing group lengths, n=1
        run_master(2, 32, 10, 5, 80);
        run_master(3, 24, 0, 8, 60);
        run_master(4, 16, 7, 1, 34);

        // R7: ext_sync ignored in master mode
        duty_sel = 3'd4; do_reset();
        repeat (3) tick();
        @(negedge clk) ext_sync = 1'b1; line_tick = 1'b1;
        @(negedge clk) ext_sync = 1'b0; line_tick = 1'b0;
        chk("R7 ext_sync ignored in master", com_idx, 4);

        // R9: clear mid-frame
        duty_sel = 3'd2; do_reset();
        cfg(20, 2, 1'b1);
        repeat (10) tick();
        chk("R9 count before clear", com_idx, 10);
        chk("R9 row before clear", ram_row, 30);
        fr_keep = fr_out;
        chk("R6 fr after 10 lines n=3", fr_keep, 1);
        @(negedge clk) cmd_clr = 1'b1; cfg_wr = 1'b1; cfg_start = 7'd9;
        @(negedge clk) cmd_clr = 1'b0; cfg_wr = 1'b0;
        chk("R9 count kept", com_idx, 10);
        chk("R9 start cleared", ram_row, 10);
        chk("R9 fr kept", fr_out, fr_keep);
        repeat (2) tick();
        chk("R9 inversion cleared", fr_out, fr_keep);
        chk("R9 row follows count", ram_row, 12);

        // R10: duty shrink below current line
        duty_sel = 3'd0; do_reset();
        repeat (40) tick();
        chk("R10 count before shrink", com_idx, 40);
        duty_sel = 3'd4;
        tick();
        chk("R10 forced wrap", com_idx, 0);
        tick();
        chk("R10 after wrap", com_idx, 1);

        // R8: slave mode
        duty_sel = 3'd4; do_reset();
        @(negedge clk) is_master = 1'b0; ext_fr = 1'b1;
        @(negedge clk);
        chk("R8 fr passthrough high", fr_out, 1);
        chk("R8 no sync", sync_out, 0);
        ext_fr = 1'b0;
        @(negedge clk);
        chk("R8 fr passthrough low", fr_out, 0);
        repeat (7) tick();
        chk("R8 slave counts", com_idx, 7);
        @(negedge clk) ext_sync = 1'b1;
        @(negedge clk);
        chk("R8 sync without tick no effect", com_idx, 7);
        tick();
        chk("R8 resync to 0", com_idx, 0);
        chk("R8 no sync at line 0", sync_out, 0);
        @(negedge clk) ext_sync = 1'b0;
        tick();
        chk("R8 count after resync", com_idx, 1);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule